// File: doc/BRIEF.md
# Read Burst Sequencer

This block produces the data-return half of a double-data-rate memory device when it serves read commands. Each read command carries a starting column (three bits), a per-command chop request and the full eight-word prefetch of the addressed location. The prefetch is captured in the cycle the command arrives. After the programmed total read latency, the words are sent out one per clock. They leave in either sequential or interleaved order, and the burst holds either eight or four beats.

The total latency is the CAS latency plus an additive latency. The additive latency is chosen from three encodings that depend on CAS latency. An invalid latency setting rejects the command and raises an error pulse. A command that comes before the previous accepted burst has had room to finish on the output is dropped and flagged as a collision. Correctly spaced reads stream out with no idle cycle between bursts. Several reads may wait in their latency window at the same time, and each keeps its own captured data and ordering.

Top module: `rd_burst_seq`

## Requirements
- R1: While `rst_n` is low, `dout_valid`, `dout_last`, `dout_data`, `cmd_err` and `cmd_collide` are all 0.
- R2: For a read accepted at clock edge k, the first beat is on `dout_valid`/`dout_data` right after edge k+AL+CL, and the following beats come on consecutive cycles.
- R3: `cfg_al_sel` sets AL as follows: 0 gives AL=0, 1 gives AL=CL-1, 2 gives AL=CL-2. The value 3 rejects every command, and that command gives `cmd_err` and no beats.
- R4: A command issued while `cfg_cl` is outside 5..11 produces no beats. Right after its edge, `cmd_err` is 1 for exactly one cycle and `cmd_collide` is 0.
- R5: `cfg_bl_mode` sets the burst length: 0 gives 8 beats, 1 gives 4 beats, and 2 or 3 give 4 beats when `cmd_chop`=1 and 8 when it is 0.
- R6: In sequential order (`cfg_interleave`=0), beat i of an 8-beat burst carries word (col+i) mod 8. Beat i of a 4-beat burst carries word {col[2], (col[1:0]+i) mod 4}.
- R7: In interleaved order (`cfg_interleave`=1), beat i carries word col XOR i, for both burst lengths.
- R8: `dout_last` is 1 on exactly the final beat of each burst and never without `dout_valid`.
- R9: Accepted reads spaced exactly the previous accepted burst's length apart produce one unbroken run of beats with no idle cycle.
- R10: A valid-latency command arriving fewer cycles after the previous accepted read than that read's burst length is dropped: `cmd_collide` pulses for one cycle, no beats come from it, and the spacing is still counted from the earlier accepted read.
- R11: Word k of the prefetch is `cmd_data[k*W +: W]` as sampled at the command edge. Later changes on `cmd_data` do not affect that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl | input | CL_W | CAS latency in cycles, valid 5..11 |
| cfg_al_sel | input | 2 | Additive latency select: 0 none, 1 CL-1, 2 CL-2, 3 invalid |
| cfg_bl_mode | input | 2 | Burst length mode: 0 eight, 1 four, 2/3 per command |
| cfg_interleave | input | 1 | 1 selects interleaved beat order, 0 sequential |
| cmd_valid | input | 1 | Read command strobe, one cycle per command |
| cmd_col | input | 3 | Starting column within the eight-word group |
| cmd_chop | input | 1 | Per-command four-beat request (used in modes 2/3) |
| cmd_data | input | 8*W | Prefetched eight words, word k at bits k*W upward |
| dout_valid | output | 1 | Beat valid |
| dout_data | output | W | Beat word, zero when not valid |
| dout_last | output | 1 | Final beat of a burst |
| cmd_err | output | 1 | One-cycle pulse: command rejected for invalid latency |
| cmd_collide | output | 1 | One-cycle pulse: command dropped for spacing |

## Verification
The error and collision flags are registered, so both are due in the cycle right after the command edge. A burst's first beat is due exactly AL+CL edges after the command, and its beats follow on the next edges. The bench's reference model works out these due cycles when it sees the command and files the expected beat, last flag and pulses under the absolute edge number. Every output is compared on the falling edge that follows each rising edge, against the entry for that edge. An output that is early, late or extra is therefore reported in the cycle it occurs.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  // Eight words per prefetch: the beat index is three bits wide.
  localparam int unsigned BEATS = 8;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [1:0] {
    BL_FIXED8 = 2'd0,
    BL_FIXED4 = 2'd1,
    BL_OTF_A  = 2'd2,
    BL_OTF_B  = 2'd3
  } bl_mode_e;

  typedef enum logic [1:0] {
    AL_ZERO = 2'd0,
    AL_CLM1 = 2'd1,
    AL_CLM2 = 2'd2,
    AL_BAD  = 2'd3
  } al_sel_e;

  typedef struct packed {
    logic             chop;
    logic             ilv;
    logic [IDX_W-1:0] start;
  } burst_ctl_t;

  // Word index of beat n within a burst.
  function automatic logic [IDX_W-1:0] beat_index(input burst_ctl_t c,
                                                  input logic [IDX_W-1:0] n);
    logic [IDX_W-1:0] sum;
    sum = c.start + n;
    if (c.ilv)       return c.start ^ n;
    else if (c.chop) return {c.start[IDX_W-1], sum[IDX_W-2:0]};
    else             return sum;
  endfunction

endpackage

// File: rtl/rbs_cmd_check.sv
module rbs_cmd_check
  import rbs_pkg::*;
#(
  parameter int unsigned CL_W   = 4,
  parameter int unsigned CL_MIN = 5,
  parameter int unsigned CL_MAX = 11,
  parameter int unsigned LAT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_chop,
  input  logic [CL_W-1:0]  cfg_cl,
  input  logic [1:0]       cfg_al_sel,
  input  logic [1:0]       cfg_bl_mode,
  output logic             accept,
  output logic             chop_eff,
  output logic [LAT_W-1:0] lat,
  output logic             err_q,
  output logic             collide_q
);

  localparam int unsigned GAP_W = CNT_W;
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(BEATS);
  localparam logic [GAP_W-1:0] LEN_FULL = GAP_W'(BEATS);
  localparam logic [GAP_W-1:0] LEN_CHOP = GAP_W'(BEATS / 2);

  logic [CL_W-1:0]  al_val;
  logic             cl_ok, al_ok, lat_ok;
  logic             hit;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             len8_q, len8_d;
  logic [GAP_W-1:0] prev_len;
  logic             err_d, collide_d;

  always_comb begin
    cl_ok = (cfg_cl >= CL_W'(CL_MIN)) && (cfg_cl <= CL_W'(CL_MAX));
    al_ok = 1'b1;
    unique case (al_sel_e'(cfg_al_sel))
      AL_ZERO: al_val = '0;
      AL_CLM1: al_val = cfg_cl - CL_W'(1);
      AL_CLM2: al_val = cfg_cl - CL_W'(2);
      default: begin
        al_val = '0;
        al_ok  = 1'b0;
      end
    endcase
    lat_ok = cl_ok && al_ok;
    lat    = LAT_W'(cfg_cl) + LAT_W'(al_val);
  end

  always_comb begin
    unique case (bl_mode_e'(cfg_bl_mode))
      BL_FIXED8: chop_eff = 1'b0;
      BL_FIXED4: chop_eff = 1'b1;
      default:   chop_eff = cmd_chop;
    endcase
  end

  assign prev_len = len8_q ? LEN_FULL : LEN_CHOP;
  assign hit      = cmd_valid && lat_ok && (gap_q < prev_len);
  assign accept   = cmd_valid && lat_ok && !hit;

  always_comb begin
    gap_d     = gap_q;
    len8_d    = len8_q;
    err_d     = cmd_valid && !lat_ok;
    collide_d = hit;
    if (accept) begin
      gap_d  = GAP_W'(1);
      len8_d = !chop_eff;
    end else if (gap_q != GAP_MAX) begin
      gap_d = gap_q + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= GAP_MAX;
      len8_q    <= 1'b0;
      err_q     <= 1'b0;
      collide_q <= 1'b0;
    end else begin
      gap_q     <= gap_d;
      len8_q    <= len8_d;
      err_q     <= err_d;
      collide_q <= collide_d;
    end
  end

endmodule

// File: rtl/rbs_slot_array.sv
module rbs_slot_array
  import rbs_pkg::*;
#(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned W     = 16,
  parameter int unsigned LAT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LAT_W-1:0]   load_lat,
  input  burst_ctl_t         load_ctl,
  input  logic [BEATS*W-1:0] load_data,
  output logic               take,
  output burst_ctl_t         take_ctl,
  output logic [BEATS*W-1:0] take_data
);

  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0]   act_vec;
  logic [NSLOT-1:0]   rdy_vec;
  burst_ctl_t         ctl_arr [NSLOT];
  logic [BEATS*W-1:0] dat_arr [NSLOT];
  logic [SLOT_W-1:0]  free_sel, rdy_sel;
  logic               free_ok, rdy_ok;

  // Lowest-index free slot and lowest-index slot whose wait has ended.
  always_comb begin
    free_ok  = 1'b0;
    free_sel = '0;
    rdy_ok   = 1'b0;
    rdy_sel  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!act_vec[i]) begin
        free_ok  = 1'b1;
        free_sel = SLOT_W'(i);
      end
      if (rdy_vec[i]) begin
        rdy_ok  = 1'b1;
        rdy_sel = SLOT_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic               act_q, act_d;
    logic [LAT_W-1:0]   cnt_q, cnt_d;
    burst_ctl_t         ctl_q;
    logic [BEATS*W-1:0] dat_q;
    logic               ld_en, tk_en;

    assign ld_en = load && free_ok && (free_sel == SLOT_W'(g));
    assign tk_en = rdy_ok && (rdy_sel == SLOT_W'(g));

    always_comb begin
      act_d = act_q;
      cnt_d = cnt_q;
      if (act_q && (cnt_q != '0)) cnt_d = cnt_q - LAT_W'(1);
      if (tk_en) act_d = 1'b0;
      if (ld_en) begin
        act_d = 1'b1;
        cnt_d = load_lat - LAT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        act_q <= act_d;
        cnt_q <= cnt_d;
      end
    end

    always_ff @(posedge clk) begin
      if (ld_en) begin
        ctl_q <= load_ctl;
        dat_q <= load_data;
      end
    end

    assign act_vec[g] = act_q;
    assign rdy_vec[g] = act_q && (cnt_q == '0);
    assign ctl_arr[g] = ctl_q;
    assign dat_arr[g] = dat_q;
  end

  assign take      = rdy_ok;
  assign take_ctl  = ctl_arr[rdy_sel];
  assign take_data = dat_arr[rdy_sel];

endmodule

// File: rtl/rbs_serializer.sv
module rbs_serializer
  import rbs_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  burst_ctl_t         start_ctl,
  input  logic [BEATS*W-1:0] start_data,
  output logic               dout_valid,
  output logic [W-1:0]       dout_data,
  output logic               dout_last
);

  localparam logic [CNT_W-1:0] REM_FULL = CNT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0] REM_CHOP = CNT_W'(BEATS / 2 - 1);

  burst_ctl_t         cur_ctl;
  logic [BEATS*W-1:0] cur_dat;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [IDX_W-1:0]   nxt_q, nxt_d;
  logic               emit, ld;
  logic [IDX_W-1:0]   idx;
  logic [BEATS*W-1:0] src;
  logic               v_d, l_d;
  logic [W-1:0]       d_d;

  always_comb begin
    emit   = 1'b0;
    ld     = 1'b0;
    idx    = '0;
    src    = cur_dat;
    left_d = left_q;
    nxt_d  = nxt_q;
    if (start) begin
      emit   = 1'b1;
      ld     = 1'b1;
      idx    = beat_index(start_ctl, IDX_W'(0));
      src    = start_data;
      left_d = start_ctl.chop ? REM_CHOP : REM_FULL;
      nxt_d  = IDX_W'(1);
    end else if (left_q != '0) begin
      emit   = 1'b1;
      idx    = beat_index(cur_ctl, nxt_q);
      left_d = left_q - CNT_W'(1);
      nxt_d  = nxt_q + IDX_W'(1);
    end
    v_d = emit;
    l_d = emit && (left_d == '0);
    d_d = emit ? src[idx*W +: W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q     <= '0;
      nxt_q      <= '0;
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
      dout_data  <= '0;
    end else begin
      left_q     <= left_d;
      nxt_q      <= nxt_d;
      dout_valid <= v_d;
      dout_last  <= l_d;
      dout_data  <= d_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      cur_ctl <= start_ctl;
      cur_dat <= start_data;
    end
  end

endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
  import rbs_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned CL_W   = 4,
  parameter int unsigned CL_MIN = 5,
  parameter int unsigned CL_MAX = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CL_W-1:0]    cfg_cl,
  input  logic [1:0]         cfg_al_sel,
  input  logic [1:0]         cfg_bl_mode,
  input  logic               cfg_interleave,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_col,
  input  logic               cmd_chop,
  input  logic [8*W-1:0]     cmd_data,
  output logic               dout_valid,
  output logic [W-1:0]       dout_data,
  output logic               dout_last,
  output logic               cmd_err,
  output logic               cmd_collide
);

  localparam int unsigned LAT_W = $clog2(2 * CL_MAX + 1);

  logic               accept, chop_eff;
  logic [LAT_W-1:0]   lat;
  burst_ctl_t         new_ctl;
  logic               take;
  burst_ctl_t         take_ctl;
  logic [BEATS*W-1:0] take_data;

  rbs_cmd_check #(
    .CL_W   (CL_W),
    .CL_MIN (CL_MIN),
    .CL_MAX (CL_MAX),
    .LAT_W  (LAT_W)
  ) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_chop    (cmd_chop),
    .cfg_cl      (cfg_cl),
    .cfg_al_sel  (cfg_al_sel),
    .cfg_bl_mode (cfg_bl_mode),
    .accept      (accept),
    .chop_eff    (chop_eff),
    .lat         (lat),
    .err_q       (cmd_err),
    .collide_q   (cmd_collide)
  );

  assign new_ctl = '{chop: chop_eff, ilv: cfg_interleave, start: cmd_col};

  rbs_slot_array #(
    .NSLOT (NSLOT),
    .W     (W),
    .LAT_W (LAT_W)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_lat  (lat),
    .load_ctl  (new_ctl),
    .load_data (cmd_data),
    .take      (take),
    .take_ctl  (take_ctl),
    .take_data (take_data)
  );

  rbs_serializer #(
    .W (W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take),
    .start_ctl  (take_ctl),
    .start_data (take_data),
    .dout_valid (dout_valid),
    .dout_data  (dout_data),
    .dout_last  (dout_last)
  );

endmodule

// File: rtl/rd_burst_seq_chk.sv
module rd_burst_seq_chk #(
  parameter int unsigned W      = 16,
  parameter int unsigned CL_W   = 4,
  parameter int unsigned CL_MIN = 5,
  parameter int unsigned CL_MAX = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CL_W-1:0] cfg_cl,
  input logic [1:0]      cfg_al_sel,
  input logic            cmd_valid,
  input logic            dout_valid,
  input logic [W-1:0]    dout_data,
  input logic            dout_last,
  input logic            cmd_err,
  input logic            cmd_collide
);

  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (dout_valid) run_q <= dout_last ? 4'd0 : run_q + 4'd1;
  end

  // R4: out-of-range CAS latency is rejected as an error, not a collision
  a_r4_bad_cl_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && ((cfg_cl < CL_W'(CL_MIN)) || (cfg_cl > CL_W'(CL_MAX)))
    |=> cmd_err && !cmd_collide);

  // R3: additive latency code 3 is rejected
  a_r3_bad_al_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cfg_al_sel == 2'd3) |=> cmd_err);

  // R4: an error pulse always traces back to a command
  a_r4_err_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid));

  // R10: a collision pulse always traces back to a command
  a_r10_collide_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_collide |-> $past(cmd_valid));

  // R8: last flag only on a valid beat
  a_r8_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dout_last |-> dout_valid);

  // R8: a burst closes after exactly four or eight beats
  a_r8_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    dout_last |-> ((run_q == 4'd3) || (run_q == 4'd7)));

  // R1: data output is zero whenever no beat is presented
  a_r1_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout_data == '0));

endmodule

bind rd_burst_seq rd_burst_seq_chk #(
  .W      (W),
  .CL_W   (CL_W),
  .CL_MIN (CL_MIN),
  .CL_MAX (CL_MAX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_cl      (cfg_cl),
  .cfg_al_sel  (cfg_al_sel),
  .cmd_valid   (cmd_valid),
  .dout_valid  (dout_valid),
  .dout_data   (dout_data),
  .dout_last   (dout_last),
  .cmd_err     (cmd_err),
  .cmd_collide (cmd_collide)
);

// File: tb/rd_burst_seq_tb_top.sv
module rd_burst_seq_tb_top;

  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [3:0]     cfg_cl;
  logic [1:0]     cfg_al_sel;
  logic [1:0]     cfg_bl_mode;
  logic           cfg_interleave;
  logic           cmd_valid;
  logic [2:0]     cmd_col;
  logic           cmd_chop;
  logic [8*W-1:0] cmd_data;
  logic           dout_valid;
  logic [W-1:0]   dout_data;
  logic           dout_last;
  logic           cmd_err;
  logic           cmd_collide;

  always #4 clk = ~clk;

  rd_burst_seq #(.W(W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_cl         (cfg_cl),
    .cfg_al_sel     (cfg_al_sel),
    .cfg_bl_mode    (cfg_bl_mode),
    .cfg_interleave (cfg_interleave),
    .cmd_valid      (cmd_valid),
    .cmd_col        (cmd_col),
    .cmd_chop       (cmd_chop),
    .cmd_data       (cmd_data),
    .dout_valid     (dout_valid),
    .dout_data      (dout_data),
    .dout_last      (dout_last),
    .cmd_err        (cmd_err),
    .cmd_collide    (cmd_collide)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  bit           exp_v [int];
  logic [W-1:0] exp_d [int];
  bit           exp_l [int];
  bit           exp_e [int];
  bit           exp_c [int];
  string        exp_t [int];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h edge=%0d", tag, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference: on each edge, schedule the outputs a command implies.
  bit have_prev = 0;
  int last_acc  = 0;
  int last_len  = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      have_prev = 0;
    end else if (cmd_valid) begin
      int cl, al, len, lat, idx;
      bit ok;
      cl = int'(cfg_cl);
      ok = (cl >= 5) && (cl <= 11) && (cfg_al_sel != 2'd3);
      if (!ok) begin
        exp_e[cyc] = 1;
      end else begin
        al  = (cfg_al_sel == 2'd0) ? 0 : (cfg_al_sel == 2'd1) ? cl - 1 : cl - 2;
        lat = cl + al;
        len = (cfg_bl_mode == 2'd0) ? 8 : (cfg_bl_mode == 2'd1) ? 4 : (cmd_chop ? 4 : 8);
        if (have_prev && (cyc - last_acc) < last_len) begin
          exp_c[cyc] = 1;
        end else begin
          for (int i = 0; i < len; i++) begin
            if (cfg_interleave)  idx = int'(cmd_col) ^ i;
            else if (len == 4)   idx = (int'(cmd_col) & 4) | ((int'(cmd_col) + i) % 4);
            else                 idx = (int'(cmd_col) + i) % 8;
            exp_v[cyc + lat + i] = 1;
            exp_d[cyc + lat + i] = cmd_data[idx*W +: W];
            exp_t[cyc + lat + i] = cur_req;
            if (i == len - 1) exp_l[cyc + lat + i] = 1;
          end
          have_prev = 1;
          last_acc  = cyc;
          last_len  = len;
        end
      end
    end
  end

  // Compare every output once per cycle, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      bit ev;
      tag = exp_t.exists(cyc) ? exp_t[cyc] : cur_req;
      ev  = exp_v.exists(cyc);
      chk(dout_valid == ev, tag, "dout_valid", dout_valid, ev);
      if (ev) begin
        chk(dout_data == exp_d[cyc], tag, "dout_data", dout_data, exp_d[cyc]);
        chk(dout_last == exp_l.exists(cyc), tag, "dout_last", dout_last, exp_l.exists(cyc));
      end else begin
        chk(dout_last == 1'b0, tag, "dout_last idle", dout_last, 0);
      end
      chk(cmd_err == exp_e.exists(cyc), cur_req, "cmd_err", cmd_err, exp_e.exists(cyc));
      chk(cmd_collide == exp_c.exists(cyc), cur_req, "cmd_collide", cmd_collide, exp_c.exists(cyc));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] col, input logic chop);
    cmd_valid = 1'b1;
    cmd_col   = col;
    cmd_chop  = chop;
    for (int k = 0; k < 8; k++) cmd_data[k*W +: W] = W'($urandom);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R11: scramble the bus after the command edge
    for (int k = 0; k < 8; k++) cmd_data[k*W +: W] = W'($urandom);
  endtask

  task automatic set_cfg(input int cl, input int al, input int bl, input bit ilv);
    cfg_cl         = 4'(cl);
    cfg_al_sel     = 2'(al);
    cfg_bl_mode    = 2'(bl);
    cfg_interleave = ilv;
  endtask

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_col   = '0;
    cmd_chop  = 1'b0;
    cmd_data  = '0;
    set_cfg(5, 0, 0, 0);
    idle(3);
    cur_req = "R1";
    chk(dout_valid == 0, "R1", "reset dout_valid", dout_valid, 0);
    chk(dout_last == 0, "R1", "reset dout_last", dout_last, 0);
    chk(dout_data == 0, "R1", "reset dout_data", dout_data, 0);
    chk(cmd_err == 0, "R1", "reset cmd_err", cmd_err, 0);
    chk(cmd_collide == 0, "R1", "reset cmd_collide", cmd_collide, 0);
    rst_n = 1'b1;
    idle(4);

    cur_req = "R2";                       // latency and sequential eight-beat order (R6)
    issue(3'd5, 1'b0); idle(40);
    set_cfg(11, 0, 0, 0);
    issue(3'd0, 1'b0); idle(40);

    cur_req = "R6";
    set_cfg(6, 0, 0, 0);
    issue(3'd7, 1'b0); idle(40);

    cur_req = "R7";
    set_cfg(6, 0, 0, 1);
    issue(3'd3, 1'b0); idle(7);
    issue(3'd6, 1'b0); idle(40);

    cur_req = "R5";
    set_cfg(5, 0, 1, 0);
    issue(3'd6, 1'b1); idle(40);          // fixed four ignores cmd_chop=1 requirement? still four
    issue(3'd1, 1'b0); idle(40);          // fixed four even with chop low
    set_cfg(5, 0, 2, 0);
    issue(3'd2, 1'b1); idle(3);
    issue(3'd5, 1'b0); idle(40);
    set_cfg(7, 0, 3, 1);
    issue(3'd1, 1'b1); idle(3);
    issue(3'd4, 1'b0); idle(40);
    set_cfg(7, 0, 0, 0);
    issue(3'd2, 1'b1); idle(40);          // fixed eight ignores chop

    cur_req = "R3";
    set_cfg(7, 1, 0, 0);
    issue(3'd0, 1'b0); idle(40);
    set_cfg(11, 2, 0, 1);
    issue(3'd5, 1'b0); idle(40);
    set_cfg(11, 1, 1, 0);
    issue(3'd3, 1'b0); idle(40);
    set_cfg(6, 3, 0, 0);
    issue(3'd1, 1'b0); idle(40);

    cur_req = "R4";
    set_cfg(4, 0, 0, 0);
    issue(3'd0, 1'b0); idle(2);
    set_cfg(12, 0, 0, 0);
    issue(3'd1, 1'b0); idle(2);
    set_cfg(0, 0, 0, 0);
    issue(3'd2, 1'b0); idle(40);

    cur_req = "R9";
    set_cfg(8, 0, 2, 0);
    issue(3'd0, 1'b0); idle(7);
    issue(3'd4, 1'b1); idle(3);
    issue(3'd2, 1'b1); idle(3);
    issue(3'd7, 1'b0); idle(7);
    issue(3'd1, 1'b0); idle(40);

    cur_req = "R10";
    set_cfg(5, 0, 2, 0);
    issue(3'd0, 1'b0); idle(6);
    issue(3'd1, 1'b0);                    // spacing 7 after eight beats: dropped
    issue(3'd2, 1'b0); idle(7);           // spacing 8 from accepted read: taken
    issue(3'd3, 1'b1); idle(1);
    issue(3'd4, 1'b0);                    // spacing 2 after four beats: dropped
    issue(3'd5, 1'b0);                    // spacing 3: dropped
    issue(3'd6, 1'b1); idle(40);          // spacing 4: taken

    cur_req = "R11";
    set_cfg(9, 2, 0, 1);
    issue(3'd6, 1'b0); idle(3);
    issue(3'd2, 1'b1); idle(40);          // second one collides; first burst keeps its data

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog %s run did not finish", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule